// File: doc/BRIEF.md
# Compressed Instruction Expander

This block turns one 16-bit compressed instruction word into the full 32-bit base instruction that performs the same work. It is purely combinational. It is meant to sit between an instruction fetch buffer and a base-width decoder, so that the decoder only ever sees 32-bit encodings. Two flags travel with the expanded word. `isWide` marks an input that is already the low half of a 32-bit instruction, which is recognised by its two low bits being `11`. `isIllegal` marks a compressed word that this block does not translate.

Each supported compressed form is rewritten into one specific base instruction.
- Registers the short form leaves implicit are filled in: x0, the stack pointer x2, the link register x1, or the destination reused as the first source.
- A 3-bit register field r selects register 8+r.
- Immediates are collected from their scattered bit positions and rescaled. They are sign-extended or zero-extended as each form requires.

The supported forms cover:
- register and immediate arithmetic,
- word loads and stores, both general and relative to the stack pointer,
- jumps, register jumps and branches on zero.

The input fields follow the standard compressed layout:
- the quadrant is in bits [1:0];
- the major function code is in bits [15:13];
- the full register field is in bits [11:7];
- the second full register is in bits [6:2];
- the compact registers are in bits [9:7] and [4:2].

Top module: `cinstr_expander`

## Requirements
- R1: An input with bits [1:0] = 11 gives isWide=1, isIllegal=0 and expInstr=0.
- R2: Quadrant 01, funct 000 expands to addi rd,rd,imm. Quadrant 01, funct 010 expands to addi rd,x0,imm. In both, imm is bits {12,6:2} sign-extended from bit 12.
- R3: Quadrant 10, funct 100 with bits [6:2] nonzero expands to an add. With bit 12 = 0 it is add rd,x0,rs2. With bit 12 = 1 it is add rd,rd,rs2.
- R4: Quadrant 00, funct 000 expands to addi x(8+rd'),x2,uimm, where uimm is a multiple of 4 up to 1020. Quadrant 01, funct 011 with rd=2 expands to addi x2,x2,imm, where imm is a sign-extended multiple of 16. In both forms a zero immediate is illegal.
- R5: Quadrant 00, funct 010 expands to lw and funct 110 expands to sw. Both registers are x8..x15, and the offset is a zero-extended multiple of 4 up to 124.
- R6: Quadrant 10, funct 010 expands to lw rd,uimm(x2), and rd=0 is illegal. Quadrant 10, funct 110 expands to sw rs2,uimm(x2). In both the offset is a zero-extended multiple of 4 up to 252.
- R7: Quadrant 01, funct 101 expands to jal x0,off and funct 001 expands to jal x1,off. The offset is an even, signed 12-bit value.
- R8: Quadrant 10, funct 100 with bits [6:2] = 0 expands to jalr with offset 0. With bit 12 = 0 the destination is x0, and with bit 12 = 1 it is x1. A zero rs1 is illegal in both cases.
- R9: Quadrant 01, funct 110 expands to beq x(8+r),x0,off and funct 111 expands to bne. The offset is an even, signed 9-bit value.
- R10: Quadrant 01, funct 100 on x(8+r) selects an operation by bits [11:10]:
  - 00 is srli and 01 is srai, in both cases with shift amount bits [6:2];
  - 10 is andi with a sign-extended 6-bit value;
  - 11 is a register operation, chosen by bits [6:5]: 00 sub, 01 xor, 10 or, 11 and.

  A set bit 12 on a shift or a register operation is illegal.
- R11: Quadrant 10, funct 000 expands to slli rd,rd,shamt. A set bit 12 is illegal.
- R12: The all-zero word, and every compressed encoding outside R2 to R11, gives isIllegal=1, isWide=0 and expInstr=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cInstr | input | 16 | Compressed instruction word |
| expInstr | output | 32 | Expanded base instruction, zero when illegal or wide |
| isIllegal | output | 1 | Input is an unsupported compressed encoding |
| isWide | output | 1 | Input is the low half of a 32-bit instruction |

## Verification
The assertions assume that `cInstr` is a fully known 16-bit value and is held stable while the combinational outputs settle. The control strobes and the assembled word are only compared once they derive from the same input. The bench drives only defined constants, one word per clock, changing them just after the rising edge. It samples the outputs at the falling edge, so every check sees settled logic.

// File: rtl/cinstr_expand_pkg.sv
package cinstr_expand_pkg;

  localparam int CW = 16;
  localparam int XW = 32;
  localparam int RW = 5;
  localparam int PW = 3;
  localparam int OPW = 7;

  localparam logic [OPW-1:0] OPC_IMM    = 7'b0010011;
  localparam logic [OPW-1:0] OPC_LOAD   = 7'b0000011;
  localparam logic [OPW-1:0] OPC_STORE  = 7'b0100011;
  localparam logic [OPW-1:0] OPC_REG    = 7'b0110011;
  localparam logic [OPW-1:0] OPC_JAL    = 7'b1101111;
  localparam logic [OPW-1:0] OPC_JALR   = 7'b1100111;
  localparam logic [OPW-1:0] OPC_BRANCH = 7'b1100011;

  localparam logic [RW-1:0] REG_NUM_SP = 5'd2;
  localparam logic [RW-1:0] REG_NUM_RA = 5'd1;

  typedef enum logic [2:0] {FMT_I, FMT_S, FMT_R, FMT_B, FMT_J} fmtE;

  typedef enum logic [2:0] {
    REG_HI5, REG_LO5, REG_HI3, REG_LO3, REG_X0, REG_SP, REG_RA
  } regSelE;

  typedef enum logic [3:0] {
    IMM_NONE, IMM_WSPN, IMM_WORD, IMM_SMALL, IMM_SHIFT,
    IMM_SPADJ, IMM_LDSP, IMM_STSP, IMM_JUMP, IMM_BRANCH
  } immSelE;

  typedef struct packed {
    fmtE            fmt;
    logic [OPW-1:0] opcode;
    logic [2:0]     funct3;
    logic [6:0]     funct7;
    regSelE         rdSel;
    regSelE         rs1Sel;
    regSelE         rs2Sel;
    immSelE         immSel;
    logic           illegal;
    logic           wide;
  } ctrlT;

endpackage

// File: rtl/cinstr_expand_ctrl.sv
module cinstr_expand_ctrl
  import cinstr_expand_pkg::*;
(
  input  logic [CW-1:0] cInstr,
  output ctrlT          ctrl
);

  logic [1:0] quad;
  logic [2:0] major;
  logic       rdZero;
  logic       rs2Zero;

  assign quad    = cInstr[1:0];
  assign major   = cInstr[15:13];
  assign rdZero  = (cInstr[11:7] == '0);
  assign rs2Zero = (cInstr[6:2] == '0);

  always_comb begin
    ctrl         = '0;
    ctrl.fmt     = FMT_I;
    ctrl.opcode  = OPC_IMM;
    ctrl.rdSel   = REG_X0;
    ctrl.rs1Sel  = REG_X0;
    ctrl.rs2Sel  = REG_X0;
    ctrl.immSel  = IMM_NONE;
    unique case (quad)
      2'b11: ctrl.wide = 1'b1;
      2'b00: begin
        unique case (major)
          3'b000: begin
            ctrl.rdSel   = REG_LO3;
            ctrl.rs1Sel  = REG_SP;
            ctrl.immSel  = IMM_WSPN;
            ctrl.illegal = (cInstr[12:5] == '0);
          end
          3'b010: begin
            ctrl.opcode = OPC_LOAD;
            ctrl.funct3 = 3'b010;
            ctrl.rdSel  = REG_LO3;
            ctrl.rs1Sel = REG_HI3;
            ctrl.immSel = IMM_WORD;
          end
          3'b110: begin
            ctrl.fmt    = FMT_S;
            ctrl.opcode = OPC_STORE;
            ctrl.funct3 = 3'b010;
            ctrl.rs1Sel = REG_HI3;
            ctrl.rs2Sel = REG_LO3;
            ctrl.immSel = IMM_WORD;
          end
          default: ctrl.illegal = 1'b1;
        endcase
      end
      2'b01: begin
        unique case (major)
          3'b000: begin
            ctrl.rdSel  = REG_HI5;
            ctrl.rs1Sel = REG_HI5;
            ctrl.immSel = IMM_SMALL;
          end
          3'b010: begin
            ctrl.rdSel  = REG_HI5;
            ctrl.immSel = IMM_SMALL;
          end
          3'b001, 3'b101: begin
            ctrl.fmt    = FMT_J;
            ctrl.opcode = OPC_JAL;
            ctrl.rdSel  = major[2] ? REG_X0 : REG_RA;
            ctrl.immSel = IMM_JUMP;
          end
          3'b011: begin
            ctrl.rdSel   = REG_SP;
            ctrl.rs1Sel  = REG_SP;
            ctrl.immSel  = IMM_SPADJ;
            ctrl.illegal = (cInstr[11:7] != REG_NUM_SP) ||
                           (!cInstr[12] && rs2Zero);
          end
          3'b110, 3'b111: begin
            ctrl.fmt    = FMT_B;
            ctrl.opcode = OPC_BRANCH;
            ctrl.funct3 = {2'b00, major[0]};
            ctrl.rs1Sel = REG_HI3;
            ctrl.immSel = IMM_BRANCH;
          end
          default: begin
            ctrl.rdSel  = REG_HI3;
            ctrl.rs1Sel = REG_HI3;
            unique case (cInstr[11:10])
              2'b00, 2'b01: begin
                ctrl.funct3  = 3'b101;
                ctrl.funct7  = cInstr[10] ? 7'b0100000 : 7'b0000000;
                ctrl.immSel  = IMM_SHIFT;
                ctrl.illegal = cInstr[12];
              end
              2'b10: begin
                ctrl.funct3 = 3'b111;
                ctrl.immSel = IMM_SMALL;
              end
              default: begin
                ctrl.fmt     = FMT_R;
                ctrl.opcode  = OPC_REG;
                ctrl.rs2Sel  = REG_LO3;
                ctrl.illegal = cInstr[12];
                unique case (cInstr[6:5])
                  2'b00: begin ctrl.funct3 = 3'b000; ctrl.funct7 = 7'b0100000; end
                  2'b01:   ctrl.funct3 = 3'b100;
                  2'b10:   ctrl.funct3 = 3'b110;
                  default: ctrl.funct3 = 3'b111;
                endcase
              end
            endcase
          end
        endcase
      end
      default: begin
        unique case (major)
          3'b000: begin
            ctrl.funct3  = 3'b001;
            ctrl.rdSel   = REG_HI5;
            ctrl.rs1Sel  = REG_HI5;
            ctrl.immSel  = IMM_SHIFT;
            ctrl.illegal = cInstr[12];
          end
          3'b010: begin
            ctrl.opcode  = OPC_LOAD;
            ctrl.funct3  = 3'b010;
            ctrl.rdSel   = REG_HI5;
            ctrl.rs1Sel  = REG_SP;
            ctrl.immSel  = IMM_LDSP;
            ctrl.illegal = rdZero;
          end
          3'b100: begin
            if (rs2Zero) begin
              ctrl.opcode  = OPC_JALR;
              ctrl.rdSel   = cInstr[12] ? REG_RA : REG_X0;
              ctrl.rs1Sel  = REG_HI5;
              ctrl.illegal = rdZero;
            end else begin
              ctrl.fmt    = FMT_R;
              ctrl.opcode = OPC_REG;
              ctrl.rdSel  = REG_HI5;
              ctrl.rs1Sel = cInstr[12] ? REG_HI5 : REG_X0;
              ctrl.rs2Sel = REG_LO5;
            end
          end
          3'b110: begin
            ctrl.fmt    = FMT_S;
            ctrl.opcode = OPC_STORE;
            ctrl.funct3 = 3'b010;
            ctrl.rs1Sel = REG_SP;
            ctrl.rs2Sel = REG_LO5;
            ctrl.immSel = IMM_STSP;
          end
          default: ctrl.illegal = 1'b1;
        endcase
      end
    endcase

    // R1: a wide word is never reported as illegal
    a_r1_wide_not_illegal: assert (!(cInstr[1:0] == 2'b11) || (ctrl.wide && !ctrl.illegal))
      else $error("R1 wide word flagged illegal");
    // R12: the all-zero word is rejected
    a_r12_zero_word: assert (cInstr != '0 || ctrl.illegal)
      else $error("R12 zero word accepted");
  end

endmodule

// File: rtl/cinstr_expand_dp.sv
module cinstr_expand_dp
  import cinstr_expand_pkg::*;
(
  input  logic [CW-1:0] cInstr,
  input  ctrlT          ctrl,
  output logic [XW-1:0] expInstr
);

  logic [RW-1:0] rdNum, rs1Num, rs2Num;
  logic [XW-1:0] immVal;
  logic [XW-1:0] word;

  function automatic logic [RW-1:0] pickReg(regSelE sel, logic [CW-1:0] w);
    logic [RW-1:0] r;
    unique case (sel)
      REG_HI5: r = w[11:7];
      REG_LO5: r = w[6:2];
      REG_HI3: r = {2'b01, w[9:7]};
      REG_LO3: r = {2'b01, w[4:2]};
      REG_SP:  r = REG_NUM_SP;
      REG_RA:  r = REG_NUM_RA;
      default: r = '0;
    endcase
    return r;
  endfunction

  assign rdNum  = pickReg(ctrl.rdSel,  cInstr);
  assign rs1Num = pickReg(ctrl.rs1Sel, cInstr);
  assign rs2Num = pickReg(ctrl.rs2Sel, cInstr);

  always_comb begin
    unique case (ctrl.immSel)
      IMM_WSPN:   immVal = {22'b0, cInstr[10:7], cInstr[12:11], cInstr[5], cInstr[6], 2'b00};
      IMM_WORD:   immVal = {25'b0, cInstr[5], cInstr[12:10], cInstr[6], 2'b00};
      IMM_SMALL:  immVal = {{26{cInstr[12]}}, cInstr[12], cInstr[6:2]};
      IMM_SHIFT:  immVal = {20'b0, ctrl.funct7, cInstr[6:2]};
      IMM_SPADJ:  immVal = {{22{cInstr[12]}}, cInstr[12], cInstr[4:3], cInstr[5],
                            cInstr[2], cInstr[6], 4'b0000};
      IMM_LDSP:   immVal = {24'b0, cInstr[3:2], cInstr[12], cInstr[6:4], 2'b00};
      IMM_STSP:   immVal = {24'b0, cInstr[8:7], cInstr[12:9], 2'b00};
      IMM_JUMP:   immVal = {{20{cInstr[12]}}, cInstr[12], cInstr[8], cInstr[10:9],
                            cInstr[6], cInstr[7], cInstr[2], cInstr[11], cInstr[5:3], 1'b0};
      IMM_BRANCH: immVal = {{23{cInstr[12]}}, cInstr[12], cInstr[6:5], cInstr[2],
                            cInstr[11:10], cInstr[4:3], 1'b0};
      default:    immVal = '0;
    endcase
  end

  always_comb begin
    unique case (ctrl.fmt)
      FMT_S:   word = {immVal[11:5], rs2Num, rs1Num, ctrl.funct3, immVal[4:0], ctrl.opcode};
      FMT_R:   word = {ctrl.funct7, rs2Num, rs1Num, ctrl.funct3, rdNum, ctrl.opcode};
      FMT_B:   word = {immVal[12], immVal[10:5], rs2Num, rs1Num, ctrl.funct3,
                       immVal[4:1], immVal[11], ctrl.opcode};
      FMT_J:   word = {immVal[20], immVal[10:1], immVal[11], immVal[19:12], rdNum, ctrl.opcode};
      default: word = {immVal[11:0], rs1Num, ctrl.funct3, rdNum, ctrl.opcode};
    endcase
    expInstr = (ctrl.illegal || ctrl.wide) ? '0 : word;

    // R5: compact base register always lands in x8..x15
    a_r5_prime_base: assert (!(ctrl.rs1Sel == REG_HI3 && !ctrl.illegal && !ctrl.wide)
                             || expInstr[19:18] == 2'b01)
      else $error("R5 compact base outside x8..x15");
    // R4: stack-relative add reads x2
    a_r4_sp_source: assert (!(ctrl.immSel == IMM_WSPN && !ctrl.illegal && !ctrl.wide)
                            || expInstr[19:15] == REG_NUM_SP)
      else $error("R4 stack add not based on x2");
    // R7: jumps only link into x0 or x1
    a_r7_link_reg: assert (expInstr[6:0] != OPC_JAL || expInstr[11:8] == 4'b0000)
      else $error("R7 jump links into wrong register");
    // R9: branches compare against x0
    a_r9_zero_compare: assert (expInstr[6:0] != OPC_BRANCH || expInstr[24:20] == '0)
      else $error("R9 branch second source not x0");
  end

endmodule

// File: rtl/cinstr_expander.sv
module cinstr_expander
  import cinstr_expand_pkg::*;
(
  input  logic [15:0] cInstr,
  output logic [31:0] expInstr,
  output logic        isIllegal,
  output logic        isWide
);

  ctrlT ctrl;

  cinstr_expand_ctrl uCtrl (
    .cInstr (cInstr),
    .ctrl   (ctrl)
  );

  cinstr_expand_dp uDp (
    .cInstr   (cInstr),
    .ctrl     (ctrl),
    .expInstr (expInstr)
  );

  assign isIllegal = ctrl.illegal && !ctrl.wide;
  assign isWide    = ctrl.wide;

endmodule

// File: tb/cinstr_expander_test.sv
`timescale 1ns/1ps
module cinstr_expander_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cInstr = '0;
  logic [31:0] expInstr;
  logic        isIllegal, isWide;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [33:0] expQ[$];
  string       tagQ[$];

  always #2.5 clk = ~clk;

  cinstr_expander uut (
    .cInstr(cInstr), .expInstr(expInstr), .isIllegal(isIllegal), .isWide(isWide)
  );

  localparam logic [6:0] OP_I = 7'b0010011, OP_L = 7'b0000011, OP_S = 7'b0100011,
                         OP_R = 7'b0110011, OP_J = 7'b1101111, OP_JR = 7'b1100111,
                         OP_B = 7'b1100011;

  function automatic logic [31:0] encI(logic [31:0] imm, int rs1, int f3, int rd, logic [6:0] op);
    return {imm[11:0], rs1[4:0], f3[2:0], rd[4:0], op};
  endfunction
  function automatic logic [31:0] encS(logic [31:0] imm, int rs2, int rs1);
    return {imm[11:5], rs2[4:0], rs1[4:0], 3'b010, imm[4:0], OP_S};
  endfunction
  function automatic logic [31:0] encR(logic [6:0] f7, int rs2, int rs1, int f3, int rd);
    return {f7, rs2[4:0], rs1[4:0], f3[2:0], rd[4:0], OP_R};
  endfunction
  function automatic logic [31:0] encB(logic [31:0] o, int rs1, int f3);
    return {o[12], o[10:5], 5'd0, rs1[4:0], f3[2:0], o[4:1], o[11], OP_B};
  endfunction
  function automatic logic [31:0] encJ(logic [31:0] o, int rd);
    return {o[20], o[10:1], o[11], o[19:12], rd[4:0], OP_J};
  endfunction

  function automatic logic [15:0] cWspn(int rdp, logic [31:0] u);
    return {3'b000, u[5:4], u[9:6], u[2], u[3], rdp[2:0], 2'b00};
  endfunction
  function automatic logic [15:0] cMemW(bit st, int rb, int rv, logic [31:0] u);
    return {st ? 3'b110 : 3'b010, u[5:3], rb[2:0], u[2], u[6], rv[2:0], 2'b00};
  endfunction
  function automatic logic [15:0] cCi(logic [2:0] f, int rd, logic [31:0] imm);
    return {f, imm[5], rd[4:0], imm[4:0], 2'b01};
  endfunction
  function automatic logic [15:0] cJmp(bit link, logic [31:0] o);
    return {link ? 3'b001 : 3'b101, o[11], o[4], o[9:8], o[10], o[6], o[7], o[3:1], o[5], 2'b01};
  endfunction
  function automatic logic [15:0] cSpAdj(logic [31:0] n);
    return {3'b011, n[9], 5'd2, n[4], n[6], n[8:7], n[5], 2'b01};
  endfunction
  function automatic logic [15:0] cAlu(logic [1:0] k, int rdp, logic [31:0] v);
    return {3'b100, v[5], k, rdp[2:0], v[4:0], 2'b01};
  endfunction
  function automatic logic [15:0] cReg(logic [1:0] s, int rdp, int rs2p);
    return {3'b100, 1'b0, 2'b11, rdp[2:0], s, rs2p[2:0], 2'b01};
  endfunction
  function automatic logic [15:0] cBr(bit ne, int rs1p, logic [31:0] o);
    return {ne ? 3'b111 : 3'b110, o[8], o[4:3], rs1p[2:0], o[7:6], o[2:1], o[5], 2'b01};
  endfunction
  function automatic logic [15:0] cSlli(int rd, logic [31:0] sh);
    return {3'b000, sh[5], rd[4:0], sh[4:0], 2'b10};
  endfunction
  function automatic logic [15:0] cLwsp(int rd, logic [31:0] u);
    return {3'b010, u[5], rd[4:0], u[4:2], u[7:6], 2'b10};
  endfunction
  function automatic logic [15:0] cCr(bit b12, int rd, int rs2);
    return {3'b100, b12, rd[4:0], rs2[4:0], 2'b10};
  endfunction
  function automatic logic [15:0] cSwsp(int rs2, logic [31:0] u);
    return {3'b110, u[5:2], u[7:6], rs2[4:0], 2'b10};
  endfunction

  task automatic drive(logic [15:0] w, logic [31:0] e, bit ill, bit wide, string tag);
    @(posedge clk);
    #1;
    cInstr = w;
    expQ.push_back({ill, wide, e});
    tagQ.push_back(tag);
  endtask

  task automatic expectOk(logic [15:0] w, logic [31:0] e, string tag);
    drive(w, e, 1'b0, 1'b0, tag);
  endtask

  task automatic expectBad(logic [15:0] w, string tag);
    drive(w, 32'h0, 1'b1, 1'b0, tag);
  endtask

  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      logic [33:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      checks++;
      if ({isIllegal, isWide, expInstr} !== e) begin
        failures++;
        $display("FAIL %s in=%h got ill=%b wide=%b out=%h exp ill=%b wide=%b out=%h",
                 t, cInstr, isIllegal, isWide, expInstr, e[33], e[32], e[31:0]);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    expectBad(16'h0000, "R12 reset zero word");
    drive(16'h0013, 32'h0, 1'b0, 1'b1, "R1 wide word");
    drive(16'hFFFF, 32'h0, 1'b0, 1'b1, "R1 wide all ones");
    expectOk(cCi(3'b000, 5, -3), encI(-3, 5, 0, 5, OP_I), "R2 c.addi");
    expectOk(cCi(3'b010, 10, 31), encI(31, 0, 0, 10, OP_I), "R2 c.li");
    expectOk(cCr(0, 11, 12), encR(7'h00, 12, 0, 0, 11), "R3 c.mv");
    expectOk(cCr(1, 7, 9), encR(7'h00, 9, 7, 0, 7), "R3 c.add");
    expectOk(cWspn(1, 1020), encI(1020, 2, 0, 9, OP_I), "R4 addi4spn max");
    expectOk(cWspn(6, 36), encI(36, 2, 0, 14, OP_I), "R4 addi4spn mixed");
    expectBad(cWspn(3, 0), "R4 addi4spn zero imm");
    expectOk(cSpAdj(-512), encI(-512, 2, 0, 2, OP_I), "R4 addi16sp neg");
    expectOk(cSpAdj(496), encI(496, 2, 0, 2, OP_I), "R4 addi16sp pos");
    expectBad(cSpAdj(0), "R4 addi16sp zero imm");
    expectOk(cMemW(0, 0, 7, 124), encI(124, 8, 2, 15, OP_L), "R5 c.lw");
    expectOk(cMemW(1, 5, 3, 64), encS(64, 11, 13), "R5 c.sw");
    expectOk(cLwsp(1, 252), encI(252, 2, 2, 1, OP_L), "R6 c.lwsp");
    expectBad(cLwsp(0, 8), "R6 c.lwsp rd zero");
    expectOk(cSwsp(31, 200), encS(200, 31, 2), "R6 c.swsp");
    expectOk(cJmp(0, -2048), encJ(-2048, 0), "R7 c.j min");
    expectOk(cJmp(0, 682), encJ(682, 0), "R7 c.j mixed");
    expectOk(cJmp(1, 2046), encJ(2046, 1), "R7 c.jal max");
    expectOk(cCr(0, 1, 0), encI(0, 1, 0, 0, OP_JR), "R8 c.jr");
    expectOk(cCr(1, 5, 0), encI(0, 5, 0, 1, OP_JR), "R8 c.jalr");
    expectBad(cCr(0, 0, 0), "R8 c.jr rs1 zero");
    expectOk(cBr(0, 2, -256), encB(-256, 10, 0), "R9 c.beqz");
    expectOk(cBr(1, 7, 254), encB(254, 15, 1), "R9 c.bnez");
    expectOk(cBr(1, 0, 170), encB(170, 8, 1), "R9 c.bnez mixed");
    expectOk(cAlu(2'b00, 4, 31), encI(31, 12, 5, 12, OP_I), "R10 c.srli");
    expectOk(cAlu(2'b01, 0, 1), encI(32'h401, 8, 5, 8, OP_I), "R10 c.srai");
    expectOk(cAlu(2'b10, 6, -32), encI(-32, 14, 7, 14, OP_I), "R10 c.andi");
    expectBad(cAlu(2'b00, 4, 32), "R10 shift bit12 set");
    expectOk(cReg(2'b00, 1, 2), encR(7'h20, 10, 9, 0, 9), "R10 c.sub");
    expectOk(cReg(2'b01, 3, 4), encR(7'h00, 12, 11, 4, 11), "R10 c.xor");
    expectOk(cReg(2'b10, 5, 6), encR(7'h00, 14, 13, 6, 13), "R10 c.or");
    expectOk(cReg(2'b11, 7, 0), encR(7'h00, 8, 15, 7, 15), "R10 c.and");
    expectBad(cReg(2'b00, 1, 2) | 16'h1000, "R10 reg op bit12 set");
    expectOk(cSlli(20, 17), encI(17, 20, 1, 20, OP_I), "R11 c.slli");
    expectBad(cSlli(20, 33), "R11 c.slli bit12 set");
    expectBad(16'h2000, "R12 unsupported quadrant0 funct001");
    expectBad(16'h9002, "R12 unsupported break form");
    expectBad(cCi(3'b011, 1, 1), "R12 upper-immediate form unsupported");
    repeat (3) @(posedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired checks=%0d", checks);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule